// File: doc/BRIEF.md
# Serial NOR Flash Target Emulator

This block is a synthesizable SPI target that behaves like a small serial NOR flash. It is meant to sit on the far side of a flash controller under test. It decodes write-enable, identification, status-read, data-read, page-program and sector-erase frames. The serial inputs are oversampled on a fast system clock, and the block works with a host running in SPI mode 0 or mode 3.

Addresses are 24 bits: a sector byte, then a page byte, then a byte offset, sent most significant byte first after the opcode. The block keeps only `SEC_KEEP` low sector bits and `PAGE_KEEP` low page bits, so higher addresses alias onto the stored slice. Program and erase frames take effect only after a write enable. They then hold the write-in-progress flag for a fixed busy interval, during which the stored array is updated one location per clock.

Opcodes: 06h write enable, 9Fh identification, 05h status read, 03h read, 02h page program, D8h sector erase.

Top module: `spi_nor_emu`

## Requirements
- R1: Bits are captured on rising sclk and the target shifts out on falling sclk, most significant bit first. Frames with sclk idling low (mode 0) and idling high (mode 3) both decode.
- R2: After opcode 9Fh the target returns 20h, 20h, 15h on the next three byte slots.
- R3: After opcode 05h every following byte slot of the same frame returns the status byte. Bit 0 is the write-in-progress flag (WIP) and bit 1 is the write-enable latch (WEL). Bits 4:2 (protection field) and bits 7:5 read 0.
- R4: WEL is set only by a frame that holds exactly one complete byte, 06h, closed by csN rising. A partial byte or an extra byte leaves WEL clear.
- R5: Opcode 03h followed by a 3-byte address streams bytes from consecutive addresses for as long as csN stays low, crossing page boundaries.
- R6: Page program (02h, 3 address bytes, then 1 or more data bytes) has an effect only while WEL is set. The byte offset wraps within the addressed page.
- R7: Programming only clears bits: the new byte is the old byte AND the data byte.
- R8: Sector erase (D8h plus 3 address bytes) sets every stored byte of the addressed sector to FFh.
- R9: A committed program or erase sets WIP for `max(BUSY_CLKS, sector slice size)` clocks. WEL clears together with WIP, and WIP is never 1 while WEL is 0.
- R10: While WIP is set, every opcode other than 05h is ignored: the target returns FFh and nothing changes.
- R11: A program or erase frame whose csN rises in the middle of a byte is discarded, and WEL stays set.
- R12: Address bits above the kept sector and page bits are ignored.
- R13: miso is held at 0 while csN is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The assertions assume that sclk and csN are slow against clk, so that every serial edge lasts long enough to pass the two-stage synchronizer and is seen exactly once. They also assume that csN stays high for several clocks between frames. The stimulus holds each sclk phase for eight clocks and leaves eight idle clocks after every frame. It changes the pins only on falling clk edges. Busy intervals are waited out by polling the status byte, never by guessing a delay.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WREN, CMD_RDID, CMD_RDSR, CMD_READ, CMD_PP, CMD_SE
  } cmd_e;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_RDID = 8'h9F;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_SE   = 8'hD8;

  localparam logic [7:0] ID_MAKER = 8'h20;
  localparam logic [7:0] ID_KIND  = 8'h20;
  localparam logic [7:0] ID_SIZE  = 8'h15;

  // strobes from frame control to the storage datapath
  typedef struct packed {
    logic        setWel;
    logic        bufClear;
    logic        bufWrite;
    logic [7:0]  bufCol;
    logic [7:0]  bufData;
    logic        startPp;
    logic        startSe;
    logic [23:0] opAddr;
  } strobe_t;

endpackage

// File: rtl/nor_emu_ctrl.sv
module nor_emu_ctrl
  import nor_emu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic        mosi,
  output logic        miso,
  input  logic        wip,
  input  logic        wel,
  input  logic [7:0]  rdData,
  output logic [23:0] rdAddr,
  output strobe_t     stb
);

  logic [1:0] sclkSync, csSync, mosiSync;
  logic       sclkQ, csQ;
  logic [7:0] shIn, txSh;
  logic [2:0] bitCnt, byteCnt;
  logic [23:0] addr;
  logic [7:0] col;
  logic       readLoad, misoQ;
  cmd_e       cmd, opDecoded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0; csSync <= '1; mosiSync <= '0;
      sclkQ <= 1'b0; csQ <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[0], sclk};
      csSync   <= {csSync[0], csN};
      mosiSync <= {mosiSync[0], mosi};
      sclkQ    <= sclkSync[1];
      csQ      <= csSync[1];
    end
  end

  logic active, sclkRise, sclkFall, csFall, csRise, byteDone, frameOk;
  logic [7:0] newByte, status, txNext;

  assign active   = ~csSync[1];
  assign sclkRise = sclkSync[1] & ~sclkQ;
  assign sclkFall = ~sclkSync[1] & sclkQ;
  assign csFall   = ~csSync[1] & csQ;
  assign csRise   = csSync[1] & ~csQ;
  assign newByte  = {shIn[6:0], mosiSync[1]};
  assign byteDone = active & sclkRise & (bitCnt == 3'd7);
  assign status   = {6'b0, wel, wip};

  always_comb begin
    unique case (newByte)
      OPC_WREN: opDecoded = CMD_WREN;
      OPC_RDID: opDecoded = CMD_RDID;
      OPC_RDSR: opDecoded = CMD_RDSR;
      OPC_READ: opDecoded = CMD_READ;
      OPC_PP:   opDecoded = CMD_PP;
      OPC_SE:   opDecoded = CMD_SE;
      default:  opDecoded = CMD_NONE;
    endcase
    if (wip && opDecoded != CMD_RDSR) opDecoded = CMD_NONE;
  end

  always_comb begin
    txNext = 8'hFF;
    if (byteCnt == 3'd0) begin
      if (opDecoded == CMD_RDID) txNext = ID_MAKER;
      else if (opDecoded == CMD_RDSR) txNext = status;
    end else if (cmd == CMD_RDID) begin
      if (byteCnt == 3'd1) txNext = ID_KIND;
      else if (byteCnt == 3'd2) txNext = ID_SIZE;
    end else if (cmd == CMD_RDSR) begin
      txNext = status;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shIn <= '0; txSh <= 8'hFF; bitCnt <= '0; byteCnt <= '0;
      addr <= '0; col <= '0; readLoad <= 1'b0; cmd <= CMD_NONE;
    end else if (csFall) begin
      bitCnt <= '0; byteCnt <= '0; cmd <= CMD_NONE;
      txSh <= 8'hFF; readLoad <= 1'b0;
    end else if (active && sclkRise) begin
      shIn   <= newByte;
      bitCnt <= bitCnt + 3'd1;
      if (bitCnt == 3'd7) begin
        if (byteCnt != 3'd7) byteCnt <= byteCnt + 3'd1;
        txSh <= txNext;
        if (byteCnt == 3'd0) cmd <= opDecoded;
        if ((cmd == CMD_READ || cmd == CMD_PP || cmd == CMD_SE) &&
            byteCnt >= 3'd1 && byteCnt <= 3'd3)
          addr <= {addr[15:0], newByte};
        if (cmd == CMD_PP && byteCnt == 3'd3) col <= newByte;
        if (cmd == CMD_PP && byteCnt >= 3'd4) col <= col + 8'd1;
        readLoad <= (cmd == CMD_READ) && (byteCnt >= 3'd3);
      end
    end else if (readLoad) begin
      txSh     <= rdData;
      addr     <= addr + 24'd1;
      readLoad <= 1'b0;
    end else if (active && sclkFall) begin
      txSh <= {txSh[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) misoQ <= 1'b0;
    else if (!active) misoQ <= 1'b0;
    else if (sclkFall) misoQ <= txSh[7];
  end

  assign miso    = misoQ;
  assign rdAddr  = addr;
  assign frameOk = csRise && (bitCnt == 3'd0);

  always_comb begin
    stb          = '0;
    stb.opAddr   = addr;
    stb.bufCol   = col;
    stb.bufData  = newByte;
    stb.bufClear = byteDone && byteCnt == 3'd0 && opDecoded == CMD_PP;
    stb.bufWrite = byteDone && cmd == CMD_PP && byteCnt >= 3'd4;
    stb.setWel   = frameOk && cmd == CMD_WREN && byteCnt == 3'd1;
    stb.startPp  = frameOk && cmd == CMD_PP && byteCnt >= 3'd5 && wel && !wip;
    stb.startSe  = frameOk && cmd == CMD_SE && byteCnt == 3'd4 && wel && !wip;
  end

endmodule

// File: rtl/nor_emu_store.sv
module nor_emu_store
  import nor_emu_pkg::*;
#(
  parameter int SEC_KEEP  = 1,
  parameter int PAGE_KEEP = 1,
  parameter int BUSY_CLKS = 1000
)(
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [23:0] rdAddr,
  output logic [7:0]  rdData,
  output logic        wip,
  output logic        wel
);

  localparam int IDX_W     = SEC_KEEP + PAGE_KEEP + 8;
  localparam int DEPTH     = 1 << IDX_W;
  localparam int SECT_W    = PAGE_KEEP + 8;
  localparam int SECT_SPAN = 1 << SECT_W;
  localparam int BUSY_LEN  = (BUSY_CLKS > SECT_SPAN) ? BUSY_CLKS : SECT_SPAN;
  localparam int CNT_W     = $clog2(BUSY_LEN + 1);
  localparam logic [CNT_W-1:0] SPAN_C = CNT_W'(SECT_SPAN);
  localparam logic [CNT_W-1:0] PAGE_C = CNT_W'(256);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BUSY_LEN - 1);

  function automatic logic [IDX_W-1:0] idxOf(input logic [23:0] a);
    return {a[16 +: SEC_KEEP], a[8 +: PAGE_KEEP], a[7:0]};
  endfunction

  logic [7:0]       mem [DEPTH];
  logic [7:0]       pageBuf [256];
  logic [255:0]     pageMask;
  logic [CNT_W-1:0] busyCnt;
  logic             wipQ, welQ, isErase;
  logic [23:0]      baseAddr;
  logic [IDX_W-1:0] baseIdx, eraseIdx, progIdx;

  assign baseIdx  = idxOf(baseAddr);
  assign eraseIdx = {baseIdx[IDX_W-1 -: SEC_KEEP], busyCnt[SECT_W-1:0]};
  assign progIdx  = {baseIdx[IDX_W-1:8], busyCnt[7:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wipQ <= 1'b0; welQ <= 1'b0; busyCnt <= '0;
      isErase <= 1'b0; baseAddr <= '0;
    end else begin
      if (stb.startPp || stb.startSe) begin
        wipQ     <= 1'b1;
        busyCnt  <= '0;
        isErase  <= stb.startSe;
        baseAddr <= stb.opAddr;
      end else if (wipQ) begin
        if (busyCnt == LAST_C) begin
          wipQ <= 1'b0;
          welQ <= 1'b0;
        end else begin
          busyCnt <= busyCnt + 1'b1;
        end
      end
      if (stb.setWel) welQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wipQ) begin
      if (isErase && busyCnt < SPAN_C)
        mem[eraseIdx] <= 8'hFF;
      else if (!isErase && busyCnt < PAGE_C && pageMask[busyCnt[7:0]])
        mem[progIdx] <= mem[progIdx] & pageBuf[busyCnt[7:0]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageMask <= '0;
    else if (stb.bufClear) pageMask <= '0;
    else if (stb.bufWrite) pageMask[stb.bufCol] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.bufWrite)
      pageBuf[stb.bufCol] <= pageMask[stb.bufCol] ?
                             (pageBuf[stb.bufCol] & stb.bufData) : stb.bufData;
  end

  assign rdData = mem[idxOf(rdAddr)];
  assign wip    = wipQ;
  assign wel    = welQ;

endmodule

// File: rtl/spi_nor_emu.sv
module spi_nor_emu
  import nor_emu_pkg::*;
#(
  parameter int SEC_KEEP  = 1,
  parameter int PAGE_KEEP = 1,
  parameter int BUSY_CLKS = 1000
)(
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic mosi,
  output logic miso
);

  strobe_t     stb;
  logic        wipFlag, welFlag;
  logic [7:0]  rdData;
  logic [23:0] rdAddr;

  nor_emu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(miso), .wip(wipFlag), .wel(welFlag), .rdData(rdData),
    .rdAddr(rdAddr), .stb(stb)
  );

  nor_emu_store #(
    .SEC_KEEP(SEC_KEEP), .PAGE_KEEP(PAGE_KEEP), .BUSY_CLKS(BUSY_CLKS)
  ) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr),
    .rdData(rdData), .wip(wipFlag), .wel(welFlag)
  );

endmodule

// File: rtl/nor_emu_checker.sv
module nor_emu_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic miso,
  input logic wip,
  input logic wel
);

  AST_WIP_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    wip |-> wel); // R9
  AST_BUSY_START_AFTER_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(wel)); // R6
  AST_WEL_SET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> !wip); // R10
  AST_BUSY_END_DROPS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel); // R9
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> (miso == 1'b0)); // R13

endmodule

bind spi_nor_emu nor_emu_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .miso(miso),
  .wip(wipFlag), .wel(welFlag)
);

// File: tb/sim_spi_nor_emu.sv
module sim_spi_nor_emu;

  localparam int HALF = 8;
  localparam int NVEC = 7;
  // {six tx bytes, byte count, checked slot, expected byte, requirement}
  localparam logic [79:0] VEC [NVEC] = '{
    {48'h03_00_00_FE_FF_FF, 4'd6, 4'd4, 8'hA5, 16'd5},  // R5
    {48'h03_00_00_FE_FF_FF, 4'd6, 4'd5, 8'h3C, 16'd5},  // R5
    {48'h03_00_00_FF_FF_FF, 4'd6, 4'd5, 8'hFF, 16'd5},  // R5 page crossing
    {48'h03_00_00_00_FF_00, 4'd5, 4'd4, 8'h77, 16'd6},  // R6 wrapped byte
    {48'h03_3E_00_FE_FF_00, 4'd5, 4'd4, 8'hA5, 16'd12}, // R12 alias
    {48'h03_01_00_00_FF_00, 4'd5, 4'd4, 8'hFF, 16'd8},  // R8 erased
    {48'h9F_FF_FF_FF_00_00, 4'd4, 4'd3, 8'h15, 16'd2}   // R2
  };

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso;
  int checks = 0, errors = 0;
  logic [7:0] txB [8];
  logic [7:0] rxB [8];

  always #5 clk = ~clk;

  spi_nor_emu u0 (.clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN),
                  .mosi(mosi), .miso(miso));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic setTx(input logic [47:0] v);
    for (int i = 0; i < 6; i++) txB[i] = v[47 - 8*i -: 8];
  endtask

  task automatic frame(input int n, input bit cpol, input int partBits);
    @(negedge clk);
    sclk = cpol; csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < n + ((partBits > 0) ? 1 : 0); b++) begin
      int nb;
      logic [7:0] r;
      nb = (b < n) ? 8 : partBits;
      r = '0;
      for (int i = 7; i > 7 - nb; i--) begin
        sclk = 1'b0; mosi = txB[b][i];
        repeat (HALF) @(negedge clk);
        r = {r[6:0], miso};
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
      end
      rxB[b] = r;
    end
    if (!cpol) begin
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    csN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wren();
    setTx(48'h06_00_00_00_00_00);
    frame(1, 1'b0, 0);
  endtask

  task automatic readStatus(output logic [7:0] s);
    setTx(48'h05_FF_FF_00_00_00);
    frame(2, 1'b0, 0);
    s = rxB[1];
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int k = 0; k < 60; k++) begin
      readStatus(s);
      if (s[0] == 1'b0) break;
    end
    chk("R9 idle status after busy", s, 8'h00);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] s;
    repeat (5) @(negedge clk);
    chk("R13 miso in reset", {7'b0, miso}, 8'h00);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R13 miso idle", {7'b0, miso}, 8'h00);
    readStatus(s);
    chk("R3 status after reset", s, 8'h00);

    // identification in both clock idle levels
    setTx(48'h9F_FF_FF_FF_00_00);
    frame(4, 1'b0, 0);
    chk("R2 maker mode0", rxB[1], 8'h20);
    chk("R2 kind mode0", rxB[2], 8'h20);
    frame(4, 1'b1, 0);
    chk("R1 maker mode3", rxB[1], 8'h20);
    chk("R1 size mode3", rxB[3], 8'h15);

    // erase sector 0; check busy status and ignored opcode
    wren();
    readStatus(s);
    chk("R4 WEL after write enable", s, 8'h02);
    setTx(48'hD8_00_00_00_00_00);
    frame(4, 1'b0, 0);
    setTx(48'h05_FF_FF_00_00_00);
    frame(3, 1'b0, 0);
    chk("R3 status busy first", rxB[1], 8'h03);
    chk("R3 status busy repeat", rxB[2], 8'h03);
    setTx(48'h9F_FF_00_00_00_00);
    frame(2, 1'b0, 0);
    chk("R10 id ignored while busy", rxB[1], 8'hFF);
    waitIdle();
    // erase sector 1
    wren();
    setTx(48'hD8_01_00_00_00_00);
    frame(4, 1'b1, 0);
    waitIdle();

    // write enable misuse
    setTx(48'h06_00_00_00_00_00);
    frame(0, 1'b0, 4);
    readStatus(s);
    chk("R4 partial enable ignored", s, 8'h00);
    setTx(48'h06_06_00_00_00_00);
    frame(2, 1'b0, 0);
    readStatus(s);
    chk("R4 two-byte enable ignored", s, 8'h00);

    // partial program discarded, WEL kept
    wren();
    setTx(48'h02_00_00_FE_00_00);
    frame(4, 1'b0, 3);
    readStatus(s);
    chk("R11 partial program keeps WEL", s, 8'h02);
    // program with wrap: FE=A5, FF=3C, 00=77
    setTx(48'h02_00_00_FE_A5_3C);
    txB[6] = 8'h77;
    frame(7, 1'b0, 0);
    waitIdle();
    // program without WEL is ignored
    setTx(48'h02_00_00_FE_00_00);
    frame(5, 1'b0, 0);
    readStatus(s);
    chk("R6 program without WEL not busy", s, 8'h00);

    // table of read-back vectors
    for (int v = 0; v < NVEC; v++) begin
      setTx(VEC[v][79:32]);
      frame(int'(VEC[v][31:28]), v[0], 0);
      chk($sformatf("R%0d table vector %0d", VEC[v][15:0], v),
          rxB[VEC[v][27:24]], VEC[v][23:16]);
    end

    // AND programming
    wren();
    setTx(48'h02_00_00_FE_0F_00);
    frame(5, 1'b0, 0);
    waitIdle();
    setTx(48'h03_00_00_FE_FF_00);
    frame(5, 1'b0, 0);
    chk("R7 program clears bits only", rxB[4], 8'h05);

    // erase cut mid-byte then aliased erase of sector 0
    wren();
    setTx(48'hD8_00_00_00_00_00);
    frame(3, 1'b0, 5);
    readStatus(s);
    chk("R11 partial erase keeps WEL", s, 8'h02);
    setTx(48'h03_00_00_FE_FF_00);
    frame(5, 1'b0, 0);
    chk("R11 partial erase no change", rxB[4], 8'h05);
    setTx(48'hD8_20_00_00_00_00);
    frame(4, 1'b0, 0);
    waitIdle();
    setTx(48'h03_00_00_FE_FF_00);
    frame(5, 1'b0, 0);
    chk("R8 R12 aliased erase", rxB[4], 8'hFF);
    chk("R13 miso after frames", {7'b0, miso}, 8'h00);

    summary();
    $finish;
  end

endmodule